// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control path and register datapath of a small non-pipelined 16-bit processor. It runs three instructions: a register add, a load from a base register plus a short signed offset, and an indirect jump through a register. Each instruction moves through a fixed order of phases: fetch, decode, evaluate address, fetch operands, execute and store result. The controller skips any phase the current instruction does not use, so it spends no idle cycle there.

The block reaches memory only through an address register and a data register. It drives a read strobe with the address register's value, and it captures the returned word into the data register one cycle later. A run flag is set at reset. Any opcode outside the supported three clears the flag and freezes the machine. Only the external start input can set the flag again, and execution then resumes at the current program counter. A read port on the register file, together with the program counter, the instruction register and a completion pulse, lets a bench compare state after a short program.

Top module: `mc_seq_core`

## Requirements
- R1: While reset is held and after it is released, pc_out is 0x0000, running is 1 and retired is 0. The first instruction is fetched from address 0.
- R2: A fetch first copies the PC into the address register and increments the PC by one. It then asserts mem_rd with mem_addr equal to that copied address. It latches mem_rdata into the data register on the following cycle, and then moves the word into ir_out.
- R3: A word with bits 15:12 = 0001 writes the 16-bit sum (modulo 2^16) of the registers selected by bits 8:6 and 2:0 into the register selected by bits 11:9.
- R4: A word with bits 15:12 = 0110 reads memory at the register selected by bits 8:6 plus the sign-extended 6-bit field in bits 5:0. The loaded word is written into the register selected by bits 11:9.
- R5: A word with bits 15:12 = 1100 loads the PC with the register selected by bits 8:6.
- R6: Skipped phases take no cycle. An add takes 8 cycles, a load takes 9 and a jump takes 7, from the start of its fetch to the start of the next fetch.
- R7: Any other opcode clears running, retires nothing and leaves pc_out at the address after that word. No register or PC changes until start is asserted.
- R8: Asserting start while halted sets running and resumes fetching at pc_out. Asserting start while running has no effect.
- R9: retired is high for exactly one cycle per completed instruction: the store-result cycle for an add or load, and the execute cycle for a jump.
- R10: dbg_data shows, combinationally, the register selected by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sets the run flag when halted |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address (address register) |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| dbg_sel | input | 3 | Register file inspection select |
| dbg_data | output | 16 | Value of the selected register |
| pc_out | output | 16 | Program counter |
| ir_out | output | 16 | Instruction register |
| running | output | 1 | Run flag |
| retired | output | 1 | One-cycle instruction completion pulse |

## Verification
The hardest case to reach from the ports is a load whose effective address comes from a negative offset applied to a base that was itself loaded earlier. Right after that case comes a jump to a target fetched from memory, followed by an add on the far side of the jump. Each vector preloads a program that builds these dependencies, then sweeps the data words, including carry-out cases. The bench checks each instruction's cycle count from the spacing of completion pulses. An unsupported word halts the program, and start is then used to run one more add after the halt. On half of the vectors start is also pulsed mid-run to show that it is ignored.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int WORD = 16;
  localparam int NREG = 8;
  localparam int RSEL = $clog2(NREG);

  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_JMP = 4'b1100;

  typedef enum logic [3:0] {
    PH_F_ADDR, PH_F_RD, PH_F_MDR, PH_F_IR, PH_DECODE, PH_EVAL,
    PH_OPND, PH_OPND_RD, PH_OPND_MDR, PH_EXEC, PH_STORE, PH_HALT
  } phase_t;

  typedef enum logic [1:0] {K_ADD, K_LDR, K_JMP, K_BAD} kind_t;

  function automatic logic [WORD-1:0] sext6(input logic [5:0] v);
    return {{(WORD-6){v[5]}}, v};
  endfunction

  function automatic logic [WORD-1:0] add_w(input logic [WORD-1:0] x,
                                            input logic [WORD-1:0] y);
    return x + y;
  endfunction
endpackage

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int SW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SW-1:0]    wsel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [SW-1:0]    sel_a,
  input  logic [SW-1:0]    sel_b,
  input  logic [SW-1:0]    sel_c,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b,
  output logic [WIDTH-1:0] rd_c
);
  logic [WIDTH-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                        regs[g] <= '0;
      else if (we && wsel == SW'(g))     regs[g] <= wdata;
    end
  end

  assign rd_a = regs[sel_a];
  assign rd_b = regs[sel_b];
  assign rd_c = regs[sel_c];
endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
(
  input  logic [WORD-1:0] ir,
  output kind_t           kind,
  output logic [RSEL-1:0] dst,
  output logic [RSEL-1:0] src1,
  output logic [RSEL-1:0] src2,
  output logic [WORD-1:0] offs
);
  always_comb begin
    unique case (ir[15:12])
      OP_ADD:  kind = K_ADD;
      OP_LDR:  kind = K_LDR;
      OP_JMP:  kind = K_JMP;
      default: kind = K_BAD;
    endcase
  end
  assign dst  = ir[11:9];
  assign src1 = ir[8:6];
  assign src2 = ir[2:0];
  assign offs = sext6(ir[5:0]);
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  kind_t  kind,
  output phase_t phase,
  output logic   run_flag,
  output logic   retire
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_F_ADDR:   nxt = PH_F_RD;
      PH_F_RD:     nxt = PH_F_MDR;
      PH_F_MDR:    nxt = PH_F_IR;
      PH_F_IR:     nxt = PH_DECODE;
      PH_DECODE: begin
        unique case (kind)
          K_LDR:   nxt = PH_EVAL;
          K_ADD,
          K_JMP:   nxt = PH_OPND;
          default: nxt = PH_HALT;
        endcase
      end
      PH_EVAL:     nxt = PH_OPND_RD;
      PH_OPND_RD:  nxt = PH_OPND_MDR;
      PH_OPND_MDR: nxt = PH_STORE;
      PH_OPND:     nxt = PH_EXEC;
      PH_EXEC:     nxt = (kind == K_JMP) ? PH_F_ADDR : PH_STORE;
      PH_STORE:    nxt = PH_F_ADDR;
      PH_HALT:     nxt = start ? PH_F_ADDR : PH_HALT;
      default:     nxt = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_F_ADDR;
      run_flag <= 1'b1;
    end else begin
      phase <= nxt;
      if (phase == PH_DECODE && kind == K_BAD) run_flag <= 1'b0;
      else if (phase == PH_HALT && start)      run_flag <= 1'b1;
    end
  end

  assign retire = (phase == PH_STORE) || (phase == PH_EXEC && kind == K_JMP);
endmodule

// File: rtl/mc_seq_core.sv
module mc_seq_core
  import mcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            mem_rd,
  output logic [WORD-1:0] mem_addr,
  input  logic [WORD-1:0] mem_rdata,
  input  logic [RSEL-1:0] dbg_sel,
  output logic [WORD-1:0] dbg_data,
  output logic [WORD-1:0] pc_out,
  output logic [WORD-1:0] ir_out,
  output logic            running,
  output logic            retired
);
  logic [WORD-1:0] pc, ir, mar, mdr, opa, opb, res;
  phase_t          phase;
  kind_t           kind;
  logic [RSEL-1:0] dst, src1, src2;
  logic [WORD-1:0] offs, rd1, rd2, wb_data;
  logic            wb_en;

  mcc_decode u_dec (
    .ir(ir), .kind(kind), .dst(dst), .src1(src1), .src2(src2), .offs(offs)
  );

  mcc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .phase(phase), .run_flag(running), .retire(retired)
  );

  assign wb_en   = (phase == PH_STORE);
  assign wb_data = (kind == K_LDR) ? mdr : res;

  mcc_regfile #(.WIDTH(WORD), .DEPTH(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wb_en), .wsel(dst), .wdata(wb_data),
    .sel_a(src1), .sel_b(src2), .sel_c(dbg_sel),
    .rd_a(rd1), .rd_b(rd2), .rd_c(dbg_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
      opa <= '0;
      opb <= '0;
      res <= '0;
    end else begin
      unique case (phase)
        PH_F_ADDR: begin
          mar <= pc;
          pc  <= add_w(pc, WORD'(1));
        end
        PH_F_MDR:    mdr <= mem_rdata;
        PH_F_IR:     ir  <= mdr;
        PH_EVAL:     mar <= add_w(rd1, offs);
        PH_OPND: begin
          opa <= rd1;
          opb <= rd2;
        end
        PH_OPND_MDR: mdr <= mem_rdata;
        PH_EXEC: begin
          if (kind == K_JMP) pc  <= opa;
          else               res <= add_w(opa, opb);
        end
        default: ;
      endcase
    end
  end

  assign mem_rd   = (phase == PH_F_RD) || (phase == PH_OPND_RD);
  assign mem_addr = mar;
  assign pc_out   = pc;
  assign ir_out   = ir;
endmodule

// File: rtl/mcc_chk.sv
module mcc_chk
  import mcc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            running,
  input logic            retired,
  input logic            mem_rd,
  input logic [WORD-1:0] pc_out,
  input phase_t          phase
);
  p_fetch_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_F_ADDR |=> pc_out == $past(pc_out) + 16'd1);

  p_mdr_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (phase == PH_F_MDR || phase == PH_OPND_MDR));

  p_ir_to_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_F_IR |=> phase == PH_DECODE);

  p_ldr_skips_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EVAL |=> phase == PH_OPND_RD);

  p_halt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HALT && !start) |=> (phase == PH_HALT && $stable(pc_out) && !running));

  p_start_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HALT && start) |=> (phase == PH_F_ADDR && running));

  p_retire_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retired |-> running);

  p_retire_then_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retired |=> (phase == PH_F_ADDR && !retired));
endmodule

bind mc_seq_core mcc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running),
  .retired(retired), .mem_rd(mem_rd), .pc_out(pc_out), .phase(phase)
);

// File: tb/mc_seq_core_tb.sv
module mc_seq_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr, mem_rdata, dbg_data, pc_out, ir_out;
  logic [2:0]  dbg_sel = 3'd0;
  logic        running, retired;

  logic [15:0] mem [256];
  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  mc_seq_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dbg_sel(dbg_sel),
    .dbg_data(dbg_data), .pc_out(pc_out), .ir_out(ir_out),
    .running(running), .retired(retired)
  );

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    cyc <= rst_n ? cyc + 1 : 0;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_chk(input string req, input int r, input logic [15:0] exp);
    dbg_sel = 3'(r);
    #1;
    chk(req, dbg_data, exp);
  endtask

  // wait (on negedges) until running drops, recording retire times
  task automatic run_to_halt(output int nret, ref int at[16], input bit poke);
    nret = 0;
    for (int k = 0; k < 600 && running; k++) begin
      @(negedge clk);
      start = (poke && nret == 3);
      if (retired) begin
        if (nret < 16) at[nret] = cyc;
        nret++;
      end
    end
    start = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lens[8] = '{9, 9, 8, 9, 9, 9, 7, 8};
    for (int v = 0; v < 24; v++) begin
      logic [15:0] a, b, c, s;
      int nret, prev, ret2, pc_hold;
      int at[16];
      a = 16'(v * 16'h0F1D) ^ 16'(v << 11);
      b = 16'hFFFF - 16'(v * 7);
      c = 16'(v * 16'h1111) ^ 16'h00A5;
      s = a + b;
      for (int i = 0; i < 256; i++) mem[i] = 16'hF000;
      mem[0] = 16'h6214;  // LDR R1,R0,#20
      mem[1] = 16'h6615;  // LDR R3,R0,#21
      mem[2] = 16'h1E43;  // ADD R7,R1,R3
      mem[3] = 16'h6816;  // LDR R4,R0,#22
      mem[4] = 16'h6B38;  // LDR R5,R4,#-8
      mem[5] = 16'h6C17;  // LDR R6,R0,#23
      mem[6] = 16'hC180;  // JMP R6
      mem[48] = 16'h15C7; // ADD R2,R7,R7
      mem[20] = a; mem[21] = b; mem[22] = 16'd40; mem[23] = 16'd48; mem[32] = c;

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      if (v == 0) begin  // R1 reset values
        chk("R1 pc", pc_out, 16'h0000);
        chk("R1 running", 16'(running), 16'd1);
        chk("R1 retired", 16'(retired), 16'd0);
      end
      rst_n = 1'b1;
      if (v == 0) begin  // R2 first fetch address
        @(negedge clk);
        chk("R2 rd strobe", 16'(mem_rd), 16'd1);
        chk("R2 addr", mem_addr, 16'h0000);
        chk("R2 pc inc", pc_out, 16'h0001);
      end
      run_to_halt(nret, at, v[0]);

      chk("R9 retire count", 16'(nret), 16'd8);
      prev = (v == 0) ? -1 : 0;
      if (v == 0) chk("R6 first load", 16'(at[0]), 16'd8);
      for (int i = 1; i < 8; i++)  // R6/R8 phase lengths, start ignored when running
        chk("R6 cycles", 16'(at[i] - at[i-1]), 16'(lens[i]));
      reg_chk("R4 load R1", 1, a);
      reg_chk("R4 load R3", 3, b);
      reg_chk("R3 add R7", 7, s);
      reg_chk("R4 load R4", 4, 16'd40);
      reg_chk("R4 neg offset R5", 5, c);
      reg_chk("R5 target R6", 6, 16'd48);
      reg_chk("R5/R3 add after jump R2", 2, 16'(s + s));
      reg_chk("R10 R0 untouched", 0, 16'h0000);
      chk("R7 running", 16'(running), 16'd0);
      chk("R7 pc", pc_out, 16'd50);
      chk("R2 ir", ir_out, 16'hF000);

      pc_hold = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (retired || pc_out != 16'd50) pc_hold++;
      end
      chk("R7 frozen", 16'(pc_hold), 16'd0);

      mem[50] = 16'h1043;  // ADD R0,R1,R3
      mem[51] = 16'hF000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 restart", 16'(running), 16'd1);
      run_to_halt(ret2, at, 1'b0);
      chk("R8 resumed retire", 16'(ret2), 16'd1);
      reg_chk("R8 resumed add", 0, s);
      chk("R8 pc", pc_out, 16'd52);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule